// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a bus target that makes a piece of on-chip RAM look like a byte-addressed serial EEPROM on a two-wire I2C bus. It watches the clock and data lines with its own system clock. From them it picks out START, repeated START, STOP, address bytes and data bytes. It answers with acknowledge bits and read data by pulling the data line low through an open-drain enable.

The array size is a parameter, from 1 to 1024 Kbit. The size sets several things at once:

- whether the word address is one byte or two;
- the page length;
- how many bits of the 7-bit bus address are chip-select straps;
- how many bus-address bits are borrowed as the top bits of the memory address.

A master can do the following:

- random writes and page writes;
- a random read: a write of the word address, then a repeated START in the read direction, then sequential data;
- a bare read that returns one byte from the current address.

A write-protect input blocks storage without changing the bus protocol. Writes take effect at once, so no busy period is modelled.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target answers bus address 0x50 OR (CS_STRAP, limited to the select-bit count, shifted left by the borrowed-bit count). The borrowed low bits are ignored when matching. On a match it pulls SDA low in the ninth clock. On a mismatch it never drives SDA until the next START.
- R2: A write-direction START from idle loads the low borrowed bits of the bus address as the top of the word address: bits from 8 up with one-byte addressing, from 16 up with two. Address bytes then follow, high byte first when two-byte addressing is used, masked to the array size. At the default 4 Kbit size the layout is a 16-byte page, 2 select bits, 1 borrowed bit and a one-byte address.
- R3: Every data byte after the full word address is acknowledged and stored at the current address.
- R4: During writes the address advances modulo the page length. The bits above the page offset never change.
- R5: While wp_i is high, data bytes are still acknowledged and the address still advances, but the array is not changed.
- R6: A read-direction repeated START issued directly after the word address starts sequential reading. Each byte comes from the current address, and the address then advances modulo the array size.
- R7: A read-direction START from idle returns the byte at the current address and leaves the address unchanged. Any further byte in the same transfer reads 0x00.
- R8: STOP returns the transfer logic to idle from any state. So does a write-direction START in any non-idle state. So does a read-direction START in any state other than idle or waiting after the word address; the read that follows returns 0x00.
- R9: A byte written while the transfer logic is idle or in a read state is not acknowledged (SDA left high in the ninth clock).
- R10: The target keeps SDA released during the master's acknowledge bit. After a master NACK it stays released.
- R11: Reset puts the transfer logic in idle with the address counter at zero. SDA is released. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| wp_i | input | 1 | Write protect; high blocks storage |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The bench writes a page that runs past its last offset. A design that carried into the page number would place the last two bytes in the next page instead of at the page start. A sequential read starts two bytes before the array end. A design that saturated there, or wrapped within a page, would not return the bytes stored at address 0 and 1. Writes through the two bus addresses that differ only in the borrowed bit must land in different halves of the array; a design that ignored that bit would return the second write from both. A protected write must leave the old data and still advance the address; a design that gated the increment along with the store would return the wrong byte from the following bare read. Misordered STARTs must produce a NACK or 0x00, where a lax design would store or return real data.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [6:0] BUS_BASE = 7'h50;

  typedef enum logic [2:0] {
    X_IDLE, X_CUR_RD, X_ADR_HI, X_ADR_LO, X_DATA0, X_RD_SEQ, X_WR_SEQ
  } xfer_state_t;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_RECV, L_ACKO, L_SEND, L_ACKI
  } link_state_t;

  function automatic int page_bytes(input int kbit);
    if (kbit <= 2)        return 8;
    else if (kbit <= 16)  return 16;
    else if (kbit <= 64)  return 32;
    else if (kbit <= 256) return 64;
    else if (kbit <= 512) return 128;
    else                  return 256;
  endfunction

  function automatic int sel_bits(input int kbit);
    case (kbit)
      4:        return 2;
      8:        return 1;
      16:       return 0;
      128, 256: return 2;
      512:      return 2;
      1024:     return 1;
      default:  return 3;
    endcase
  endfunction

  function automatic int borrow_bits(input int kbit);
    case (kbit)
      4:       return 1;
      8:       return 2;
      16:      return 3;
      1024:    return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit two_byte_addr(input int kbit);
    return kbit >= 32;
  endfunction

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_p[STAGES-1];
  assign scl_old = scl_p[STAGES];
  assign sda_now = sda_p[STAGES-1];
  assign sda_old = sda_p[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign sda_lvl   = sda_now;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/eep_link.sv
module eep_link
  import eep_pkg::*;
#(
  parameter int          HI_BITS  = 1,
  parameter int          SEL_BITS = 2,
  parameter logic [2:0]  CS_STRAP = 3'b000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        sda_lvl,
  input  logic        start_det,
  input  logic        stop_det,
  output logic        ev_wr_start,
  output logic        ev_rd_start,
  output logic        ev_stop,
  output logic [2:0]  dev_lo,
  output logic        wr_valid,
  output logic [7:0]  wr_data,
  input  logic        wr_ack,
  output logic        rd_req,
  input  logic [7:0]  rd_data,
  output logic        sda_oe,
  output link_state_t lstate
);
  localparam logic [6:0] DONT = 7'((1 << HI_BITS) - 1);
  localparam logic [6:0] SELM = 7'((1 << SEL_BITS) - 1);
  localparam logic [6:0] MINE = BUS_BASE | ((7'(CS_STRAP) & SELM) << HI_BITS);

  link_state_t ls;
  logic [3:0]  cnt;
  logic [6:0]  sh;
  logic        ack_pend, ack_ph, to_tx, mack;

  logic [7:0] rx;
  logic       byte_done, match, edge_ok;

  assign rx        = {sh, sda_lvl};
  assign byte_done = scl_rise && (cnt == 4'd7);
  assign match     = ((rx[7:1] | DONT) == (MINE | DONT));
  assign edge_ok   = !start_det && !stop_det;

  assign ev_wr_start = edge_ok && ls == L_ADDR && byte_done && match && !rx[0];
  assign ev_rd_start = edge_ok && ls == L_ADDR && byte_done && match && rx[0];
  assign ev_stop     = stop_det;
  assign dev_lo      = rx[3:1];
  assign wr_valid    = edge_ok && ls == L_RECV && byte_done;
  assign wr_data     = rx;
  assign rd_req      = edge_ok && scl_fall &&
                       ((ls == L_ACKO && ack_ph && ack_pend && to_tx) ||
                        (ls == L_ACKI && mack));
  assign lstate      = ls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls       <= L_IDLE;
      cnt      <= '0;
      sh       <= '0;
      sda_oe   <= 1'b0;
      ack_pend <= 1'b0;
      ack_ph   <= 1'b0;
      to_tx    <= 1'b0;
      mack     <= 1'b0;
    end else if (start_det) begin
      ls     <= L_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      ls     <= L_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (ls)
        L_ADDR, L_RECV: if (scl_rise) begin
          sh <= {sh[5:0], sda_lvl};
          if (cnt == 4'd7) begin
            cnt    <= '0;
            ack_ph <= 1'b0;
            if (ls == L_ADDR) begin
              ack_pend <= match;
              to_tx    <= rx[0];
              ls       <= match ? L_ACKO : L_IDLE;
            end else begin
              ack_pend <= wr_ack;
              to_tx    <= 1'b0;
              ls       <= L_ACKO;
            end
          end else begin
            cnt <= cnt + 4'd1;
          end
        end
        L_ACKO: if (scl_fall) begin
          if (!ack_ph) begin
            sda_oe <= ack_pend;
            ack_ph <= 1'b1;
          end else if (!ack_pend) begin
            sda_oe <= 1'b0;
            ls     <= L_IDLE;
          end else if (to_tx) begin
            sh     <= rd_data[6:0];
            sda_oe <= ~rd_data[7];
            cnt    <= '0;
            ls     <= L_SEND;
          end else begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            ls     <= L_RECV;
          end
        end
        L_SEND: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              ls     <= L_ACKI;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[5:0], 1'b0};
            end
          end
        end
        L_ACKI: begin
          if (scl_rise) mack <= ~sda_lvl;
          if (scl_fall) begin
            if (mack) begin
              sh     <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              cnt    <= '0;
              ls     <= L_SEND;
            end else begin
              ls <= L_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eep_xfer.sv
module eep_xfer
  import eep_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int AW        = 9,
  parameter int PAGE      = 16,
  parameter int HI_BITS   = 1,
  parameter bit TWO       = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_wr_start,
  input  logic          ev_rd_start,
  input  logic          ev_stop,
  input  logic [2:0]    dev_lo,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          wr_ack,
  input  logic          rd_req,
  output logic [7:0]    rd_data,
  input  logic          wp_i,
  output xfer_state_t   xstate,
  output logic [AW-1:0] xaddr
);
  localparam logic [2:0]    HMASK = 3'((1 << HI_BITS) - 1);
  localparam int            SHIFT = TWO ? 16 : 8;
  localparam logic [AW-1:0] PMASK = AW'(PAGE - 1);

  xfer_state_t   st;
  logic [AW-1:0] addr;
  logic [7:0]    mem [MEM_BYTES];

  logic          in_write, mem_we;
  logic [AW-1:0] start_addr, page_next;

  assign in_write   = (st == X_DATA0) || (st == X_WR_SEQ);
  assign mem_we     = wr_valid && in_write && !wp_i;
  assign start_addr = AW'(dev_lo & HMASK) << SHIFT;
  assign page_next  = (addr & ~PMASK) | ((addr + AW'(1)) & PMASK);
  assign wr_ack     = (st == X_ADR_HI) || (st == X_ADR_LO) || in_write;
  assign rd_data    = ((st == X_CUR_RD) || (st == X_RD_SEQ)) ? mem[addr] : 8'h00;
  assign xstate     = st;
  assign xaddr      = addr;

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= X_IDLE;
      addr <= '0;
    end else if (ev_stop) begin
      st <= X_IDLE;
    end else if (ev_wr_start) begin
      if (st == X_IDLE) begin
        addr <= start_addr;
        st   <= TWO ? X_ADR_HI : X_ADR_LO;
      end else begin
        st <= X_IDLE;
      end
    end else if (ev_rd_start) begin
      case (st)
        X_IDLE:  st <= X_CUR_RD;
        X_DATA0: st <= X_RD_SEQ;
        default: st <= X_IDLE;
      endcase
    end else if (wr_valid) begin
      case (st)
        X_ADR_HI: begin
          addr <= addr | (AW'(wr_data) << 8);
          st   <= X_ADR_LO;
        end
        X_ADR_LO: begin
          addr <= addr | AW'(wr_data);
          st   <= X_DATA0;
        end
        X_DATA0, X_WR_SEQ: begin
          addr <= page_next;
          st   <= X_WR_SEQ;
        end
        default: st <= X_IDLE;
      endcase
    end else if (rd_req) begin
      case (st)
        X_CUR_RD: st <= X_IDLE;
        X_RD_SEQ: addr <= addr + AW'(1);
        default:  st <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int         MEM_KBIT = 4,
  parameter logic [2:0] CS_STRAP = 3'b001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int MEM_BYTES = MEM_KBIT * 128;
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int PAGE      = page_bytes(MEM_KBIT);
  localparam int HI_BITS   = borrow_bits(MEM_KBIT);
  localparam int SEL_BITS  = sel_bits(MEM_KBIT);
  localparam bit TWO       = two_byte_addr(MEM_KBIT);

  logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic ev_wr_start, ev_rd_start, ev_stop, wr_valid, wr_ack, rd_req;
  logic [2:0]    dev_lo;
  logic [7:0]    wr_data, rd_data;
  xfer_state_t   xst;
  link_state_t   lst;
  logic [AW-1:0] xaddr;

  eep_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_link #(.HI_BITS(HI_BITS), .SEL_BITS(SEL_BITS), .CS_STRAP(CS_STRAP)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start), .ev_stop(ev_stop),
    .dev_lo(dev_lo), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_data(rd_data), .sda_oe(sda_oe), .lstate(lst)
  );

  eep_xfer #(.MEM_BYTES(MEM_BYTES), .AW(AW), .PAGE(PAGE), .HI_BITS(HI_BITS), .TWO(TWO)) u_xfer (
    .clk(clk), .rst_n(rst_n), .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start),
    .ev_stop(ev_stop), .dev_lo(dev_lo), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ack(wr_ack), .rd_req(rd_req), .rd_data(rd_data), .wp_i(wp_i),
    .xstate(xst), .xaddr(xaddr)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
#(
  parameter int AW   = 9,
  parameter int PAGE = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_stop,
  input logic          wr_valid,
  input logic          wr_ack,
  input logic          rd_req,
  input xfer_state_t   xst,
  input link_state_t   lst,
  input logic [AW-1:0] xaddr,
  input logic          sda_oe
);
  localparam logic [AW-1:0] PM = AW'(PAGE - 1);

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> xst == X_IDLE);

  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (xst == X_DATA0 || xst == X_WR_SEQ)) |=>
      ((xaddr & ~PM) == ($past(xaddr) & ~PM)) &&
      ((xaddr & PM) == (($past(xaddr) + AW'(1)) & PM)));

  p_seq_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && xst == X_RD_SEQ) |=> xaddr == $past(xaddr) + AW'(1));

  p_nack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ack) |=> xst == X_IDLE);

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lst == L_IDLE) |-> !sda_oe);
endmodule

bind i2c_eeprom_target eep_checker #(.AW(AW), .PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .wr_valid(wr_valid),
  .wr_ack(wr_ack), .rd_req(rd_req), .xst(xst), .lst(lst),
  .xaddr(xaddr), .sda_oe(sda_oe)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] buf_q [8];
  logic [7:0] rd_q [8];

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_target i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .wp_i(wp), .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    m_sda = 1'b0; wait_q();
    scl = 1'b0;   wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q();
    scl = 1'b1;   wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_q();
      scl = 1'b1;   wait_q();
      scl = 1'b0;   wait_q();
    end
    m_sda = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    ack = ~sda_bus;
    scl = 1'b0;   wait_q();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic rel);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_q();
      scl = 1'b1; wait_q();
      b = {b[6:0], sda_bus};
      scl = 1'b0;
    end
    wait_q();
    m_sda = give_ack ? 1'b0 : 1'b1; wait_q();
    scl = 1'b1; wait_q();
    rel = ~sda_oe;
    scl = 1'b0; wait_q();
    m_sda = 1'b1;
  endtask

  task automatic wr_block(input logic [6:0] dev, input logic [7:0] word, input int n, input string req);
    logic a;
    bus_start();
    send_byte({dev, 1'b0}, a); chk(req, a, 1);
    send_byte(word, a);        chk(req, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(buf_q[i], a);  chk(req, a, 1);
    end
    bus_stop();
  endtask

  task automatic rd_block(input logic [6:0] dev, input logic [7:0] word, input int n);
    logic a, r;
    bus_start();
    send_byte({dev, 1'b0}, a);
    send_byte(word, a);
    bus_start();
    send_byte({dev, 1'b1}, a);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, rd_q[i], r);
      chk("R10 release in master ack", r, 1);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R11 sda released after reset", sda_oe, 0);
  endtask

  task automatic t_match();
    logic a;
    bus_start(); send_byte({7'h50, 1'b0}, a); bus_stop();
    chk("R1 foreign address not acked", a, 0);
    bus_start(); send_byte({7'h52, 1'b0}, a); bus_stop();
    chk("R1 own address acked", a, 1);
    bus_start(); send_byte({7'h53, 1'b0}, a); bus_stop();
    chk("R1 borrowed bit is dont-care", a, 1);
  endtask

  task automatic t_basic();
    buf_q[0] = 8'h3C; buf_q[1] = 8'h4D;
    wr_block(7'h52, 8'h00, 2, "R3 write ack");
    rd_block(7'h52, 8'h00, 2);
    chk("R3 byte 0 stored", rd_q[0], 8'h3C);
    chk("R3 byte 1 stored", rd_q[1], 8'h4D);
  endtask

  task automatic t_reset_addr();
    logic a, r;
    logic [7:0] b0, b1;
    rst_n = 1'b0; repeat (4) @(posedge clk); #1; rst_n = 1'b1; wait_q();
    chk("R11 sda released after mid-run reset", sda_oe, 0);
    bus_start();
    send_byte({7'h52, 1'b1}, a);
    recv_byte(1'b1, b0, r);
    recv_byte(1'b0, b1, r);
    chk("R10 released after master nack", sda_oe, 0);
    bus_stop();
    chk("R11 address zero after reset", b0, 8'h3C);
    chk("R7 second byte of bare read", b1, 8'h00);
  endtask

  task automatic t_page();
    buf_q[0] = 8'h61; buf_q[1] = 8'h62; buf_q[2] = 8'h63; buf_q[3] = 8'h64;
    wr_block(7'h52, 8'h1E, 4, "R4 page write ack");
    rd_block(7'h52, 8'h10, 2);
    chk("R4 wrapped byte at page start", rd_q[0], 8'h63);
    chk("R4 wrapped byte at page start+1", rd_q[1], 8'h64);
    rd_block(7'h52, 8'h1E, 2);
    chk("R4 byte at page end-1", rd_q[0], 8'h61);
    chk("R4 byte at page end", rd_q[1], 8'h62);
  endtask

  task automatic t_borrow();
    buf_q[0] = 8'h11; buf_q[1] = 8'h22; buf_q[2] = 8'h5E;
    wr_block(7'h52, 8'h05, 3, "R2 write ack");
    buf_q[0] = 8'h77;
    wr_block(7'h53, 8'h05, 1, "R2 write ack");
    rd_block(7'h53, 8'h05, 1);
    chk("R2 upper half via borrowed bit", rd_q[0], 8'h77);
    rd_block(7'h52, 8'h05, 1);
    chk("R2 lower half kept", rd_q[0], 8'h11);
  endtask

  task automatic t_wrap_end();
    buf_q[0] = 8'hE1; buf_q[1] = 8'hE2;
    wr_block(7'h53, 8'hFE, 2, "R6 write ack");
    rd_block(7'h53, 8'hFE, 4);
    chk("R6 seq read last-1", rd_q[0], 8'hE1);
    chk("R6 seq read last", rd_q[1], 8'hE2);
    chk("R6 seq read rolls to 0", rd_q[2], 8'h3C);
    chk("R6 seq read rolls to 1", rd_q[3], 8'h4D);
  endtask

  task automatic t_wp();
    logic a, r;
    logic [7:0] b;
    wp = 1'b1;
    buf_q[0] = 8'h99; buf_q[1] = 8'h98;
    wr_block(7'h52, 8'h05, 2, "R5 protected write still acked");
    wp = 1'b0;
    bus_start();
    send_byte({7'h52, 1'b1}, a);
    recv_byte(1'b0, b, r);
    bus_stop();
    chk("R5 address advanced under protect", b, 8'h5E);
    rd_block(7'h52, 8'h05, 2);
    chk("R5 byte 0 not overwritten", rd_q[0], 8'h11);
    chk("R5 byte 1 not overwritten", rd_q[1], 8'h22);
  endtask

  task automatic t_bad();
    logic a, r;
    logic [7:0] b;
    bus_start();
    send_byte({7'h52, 1'b0}, a);
    send_byte(8'h30, a);
    bus_start();
    send_byte({7'h52, 1'b0}, a);
    send_byte(8'hAA, a);
    bus_stop();
    chk("R9 data after forced idle is nacked", a, 0);
    bus_start();
    send_byte({7'h52, 1'b0}, a);
    send_byte(8'h40, a);
    send_byte(8'h12, a);
    chk("R3 data acked", a, 1);
    bus_start();
    send_byte({7'h52, 1'b1}, a);
    recv_byte(1'b0, b, r);
    bus_stop();
    chk("R8 read start after data gives zero", b, 8'h00);
    rd_block(7'h52, 8'h40, 1);
    chk("R8 byte before bad read stored", rd_q[0], 8'h12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R8: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_q();
    t_reset();
    t_match();
    t_basic();
    t_reset_addr();
    t_page();
    t_borrow();
    t_wrap_end();
    t_wp();
    t_bad();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule